// File: doc/BRIEF.md
# Dual-Bank Vectored Interrupt Controller

This block gathers 32 interrupt lines and raises two request outputs toward a processor: a normal request and a fast request. Each line first goes through a conditioning stage that both banks share. This stage can invert the line and can hold a short pulse until software acknowledges it. Every line also has a 4-bit priority, which both banks share.

Each bank has its own enable mask, pending view, winning-source readout, acknowledge port and priority threshold. A line reaches a bank only when three things are true: the line is active after conditioning, the bank has it enabled, and its priority value is not above the bank's threshold. Among the lines that qualify, the one with the numerically lowest priority wins. When two lines have the same priority, the lower line number wins.

Software uses a plain 32-bit word bus. Read data is combinational in the cycle the read is presented. Writes, and the side effect of a read, take effect at the clock edge of that cycle.

Top module: `dual_bank_intc`

## Requirements
- R1: Address map. The normal bank is at 0x000 and the fast bank at 0x100, with the same offsets in each: pending 0x00, raw 0x04, enable-set 0x08, enable-clear 0x0C, winner 0x20, acknowledge 0x28, threshold 0x2C. The shared registers are polarity at 0x200, latch-select at 0x204, and priority of line i at 0x300+4*i (bits 3:0). Out of reset, every enable is 0, every polarity bit is 1, every latch-select bit is 0, every priority is 0 and both thresholds are 0xF.
- R2: A write to enable-set unmasks each line whose data bit is 1. Data bits that are 0 leave the mask unchanged. A read of enable-set returns the mask.
- R3: A write to enable-clear masks each line whose data bit is 1. Data bits that are 0 leave the mask unchanged.
- R4: A polarity bit of 1 passes its line through unchanged. A polarity bit of 0 inverts it. Raw status shows the conditioned lines before any masking.
- R5: With latch-select 0, the line is level-sensitive: raw follows the line in the same cycle. With latch-select 1, the line is captured at the clock edge and held after the input drops.
- R6: The pending register of a bank is raw AND that bank's enables AND the threshold qualification of R7. Each request output is the OR of its bank's pending bits.
- R7: A line qualifies on a bank only when its priority value is less than or equal to that bank's threshold.
- R8: The winner register returns the qualifying line with the lowest priority value, with ties going to the lowest line number. It reads 0 when nothing is pending.
- R9: A read of acknowledge returns the winner. At that clock edge it clears the latch of the winning line, but only if that line is latched. A read of acknowledge has no effect on a level-sensitive line.
- R10: Each bank has its own enables and threshold, so one bank can assert its request output while the other stays quiet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the word accessed |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (needed for the acknowledge side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| src_in | input | 32 | Interrupt lines |
| irq_o | output | 1 | Normal request |
| fiq_o | output | 1 | Fast request |

## Verification
The hardest case to reach is an acknowledge that lands while a latched line and a level line are pending together, with the latched line winning on priority. In that case the acknowledge must clear only the latched line, after which the winner moves to the level line. The bench sets this up in four steps. It gives the level line a worse priority. It pulses the latched line for a single cycle, so that only the latch can keep it alive. It then acknowledges twice. The first acknowledge must return the latched line and clear it. The second must return the level line and leave it pending.

// File: rtl/dual_bank_intc.sv
module dual_bank_intc #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] src_in,
  output logic        irq_o,
  output logic        fiq_o
);
  localparam int IDX_W = $clog2(N_SRC);

  logic [31:0]       pol_q, stk_q, lat_q, cond, raw, clr;
  logic [PRIO_W-1:0] prio_q [N_SRC];
  logic [31:0]       en_q   [2];
  logic [PRIO_W-1:0] thr_q  [2];
  logic [31:0]       pend   [2];
  logic [IDX_W-1:0]  cur    [2];
  logic [PRIO_W:0]   best   [2];
  logic [1:0]        ack_hit;

  wire       in_bank = bus_addr[11:9] == 3'b000;
  wire       bsel    = bus_addr[8];
  wire [7:0] off     = bus_addr[7:0];
  wire       in_prio = bus_addr[11:7] == 5'b00110;
  wire [IDX_W-1:0] pidx = bus_addr[IDX_W+1:2];

  assign cond = ~(src_in ^ pol_q);
  assign raw  = (stk_q & lat_q) | (~stk_q & cond);

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      pend[b] = '0;
      cur[b]  = '0;
      best[b] = {1'b1, {PRIO_W{1'b0}}};
      for (int i = 0; i < N_SRC; i++) begin
        if (raw[i] && en_q[b][i] && prio_q[i] <= thr_q[b]) begin
          pend[b][i] = 1'b1;
          if ({1'b0, prio_q[i]} < best[b]) begin
            best[b] = {1'b0, prio_q[i]};
            cur[b]  = IDX_W'(i);
          end
        end
      end
    end
  end

  assign irq_o = |pend[0];
  assign fiq_o = |pend[1];

  for (genvar b = 0; b < 2; b++) begin : g_ack
    assign ack_hit[b] = bus_rd && in_bank && bsel == b[0] && off == 8'h28 && |pend[b];
  end
  assign clr = ((ack_hit[0] ? 32'h1 << cur[0] : 32'h0) |
                (ack_hit[1] ? 32'h1 << cur[1] : 32'h0)) & stk_q;

  always_comb begin
    bus_rdata = '0;
    if (in_bank) begin
      case (off)
        8'h00:        bus_rdata = pend[bsel];
        8'h04:        bus_rdata = raw;
        8'h08, 8'h0C: bus_rdata = en_q[bsel];
        8'h20, 8'h28: bus_rdata = 32'(cur[bsel]);
        8'h2C:        bus_rdata = 32'(thr_q[bsel]);
        default:      bus_rdata = '0;
      endcase
    end else if (bus_addr == 12'h200) bus_rdata = pol_q;
    else if (bus_addr == 12'h204) bus_rdata = stk_q;
    else if (in_prio)             bus_rdata = 32'(prio_q[pidx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '1;
      stk_q <= '0;
      lat_q <= '0;
      for (int b = 0; b < 2; b++) begin
        en_q[b]  <= '0;
        thr_q[b] <= '1;
      end
      for (int i = 0; i < N_SRC; i++) prio_q[i] <= '0;
    end else begin
      lat_q <= (lat_q | (cond & stk_q)) & ~clr;
      if (bus_wr) begin
        if (in_bank) begin
          case (off)
            8'h08:   en_q[bsel]  <= en_q[bsel] | bus_wdata;
            8'h0C:   en_q[bsel]  <= en_q[bsel] & ~bus_wdata;
            8'h2C:   thr_q[bsel] <= bus_wdata[PRIO_W-1:0];
            default: ;
          endcase
        end else if (bus_addr == 12'h200) pol_q <= bus_wdata;
        else if (bus_addr == 12'h204) stk_q <= bus_wdata;
        else if (in_prio)             prio_q[pidx] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dual_bank_intc_chk.sv
module dual_bank_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] en0,
  input logic [31:0] en1,
  input logic [31:0] raw,
  input logic [31:0] pend0,
  input logic [4:0]  cur0,
  input logic [31:0] stk,
  input logic [31:0] lat,
  input logic        irq_o,
  input logic        fiq_o
);
  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h008) |=> ((en0 & $past(bus_wdata)) == $past(bus_wdata)));
  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 12'h00C) |=> ((en0 & $past(bus_wdata)) == 32'h0));
  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((en0 & raw) != 32'h0));
  // R6
  fiq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ((en1 & raw) != 32'h0));
  // R8
  win_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend0[cur0]);
  // R8
  idle_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (cur0 == 5'd0));
  // R9
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 12'h028 && irq_o && stk[cur0]) |=> !lat[$past(cur0)]);
endmodule

bind dual_bank_intc dual_bank_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .en0(en_q[0]), .en1(en_q[1]), .raw(raw), .pend0(pend[0]),
  .cur0(cur[0]), .stk(stk_q), .lat(lat_q), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/dual_bank_intc_bench.sv
module dual_bank_intc_bench;
  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, src_in = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;
  int n_chk = 0, n_bad = 0;
  logic [31:0] d;

  dual_bank_intc u_dual_bank_intc (.*);

  always #4 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 v = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic set_src(logic [31:0] v);
    @(negedge clk); src_in = v;
  endtask

  task automatic t_reset;
    rd(12'h008, d); check("R1 irq enables", d, 0);
    rd(12'h108, d); check("R1 fiq enables", d, 0);
    rd(12'h200, d); check("R1 polarity", d, 32'hFFFF_FFFF);
    rd(12'h204, d); check("R1 latch-select", d, 0);
    rd(12'h314, d); check("R1 prio5", d, 0);
    rd(12'h02C, d); check("R1 irq thr", d, 32'hF);
    rd(12'h12C, d); check("R1 fiq thr", d, 32'hF);
    rd(12'h020, d); check("R8 idle winner", d, 0);
    check("R1 irq_o", {31'b0, irq_o}, 0);
    check("R1 fiq_o", {31'b0, fiq_o}, 0);
  endtask

  task automatic t_enable;
    wr(12'h008, 32'h0000_00F0); rd(12'h008, d); check("R2 set", d, 32'hF0);
    wr(12'h008, 32'h0);         rd(12'h008, d); check("R2 zero no effect", d, 32'hF0);
    wr(12'h00C, 32'h30);        rd(12'h00C, d); check("R3 clear", d, 32'hC0);
    wr(12'h00C, 32'h0);         rd(12'h008, d); check("R3 zero no effect", d, 32'hC0);
    rd(12'h108, d); check("R10 fiq mask untouched", d, 0);
    wr(12'h00C, 32'hFFFF_FFFF);
  endtask

  task automatic t_polarity;
    set_src(32'h0);
    wr(12'h200, 32'hFFFF_FFFE);
    rd(12'h004, d); check("R4 inverted low", d, 32'h1);
    set_src(32'h1);
    rd(12'h004, d); check("R4 inverted high", d, 32'h0);
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h004, d); check("R4 pass-through", d, 32'h1);
    set_src(32'h0);
  endtask

  task automatic t_priority;
    set_src(32'h0000_0228);
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h30C, 7); wr(12'h314, 2); wr(12'h324, 2);
    rd(12'h000, d); check("R6 pending", d, 32'h228);
    check("R6 irq_o", {31'b0, irq_o}, 1);
    rd(12'h020, d); check("R8 tie low index", d, 5);
    wr(12'h30C, 1);
    rd(12'h020, d); check("R8 lowest prio", d, 3);
    wr(12'h02C, 0);
    rd(12'h000, d); check("R7 thr blocks", d, 0);
    check("R7 irq_o low", {31'b0, irq_o}, 0);
    rd(12'h020, d); check("R8 none winner 0", d, 0);
    wr(12'h02C, 1);
    rd(12'h000, d); check("R7 prio equal thr passes", d, 32'h8);
    wr(12'h02C, 32'hF);
    wr(12'h30C, 0); wr(12'h314, 0); wr(12'h324, 0);
    wr(12'h00C, 32'hFFFF_FFFF);
    set_src(32'h0);
  endtask

  task automatic t_fiq;
    set_src(32'h0000_0200);
    wr(12'h108, 32'h200);
    rd(12'h120, d); check("R10 fiq winner", d, 9);
    check("R10 fiq_o", {31'b0, fiq_o}, 1);
    check("R10 irq_o quiet", {31'b0, irq_o}, 0);
    wr(12'h324, 1); wr(12'h12C, 0);
    check("R7 fiq thr blocks", {31'b0, fiq_o}, 0);
    wr(12'h12C, 32'hF); wr(12'h324, 0);
    wr(12'h10C, 32'hFFFF_FFFF);
    set_src(32'h0);
  endtask

  task automatic t_sticky;
    wr(12'h204, 32'h1000);
    wr(12'h310, 3);
    wr(12'h008, 32'h1010);
    set_src(32'h0000_1010);
    set_src(32'h0000_0010);
    rd(12'h004, d); check("R5 latch holds", d, 32'h1010);
    rd(12'h020, d); check("R8 latched wins", d, 12);
    rd(12'h028, d); check("R9 ack returns winner", d, 12);
    rd(12'h004, d); check("R9 latch cleared", d, 32'h10);
    rd(12'h028, d); check("R9 ack level returns", d, 4);
    rd(12'h004, d); check("R9 level unaffected", d, 32'h10);
    set_src(32'h0);
    rd(12'h004, d); check("R5 level follows", d, 0);
    check("R6 irq_o idle", {31'b0, irq_o}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset; t_enable; t_polarity; t_priority; t_fiq; t_sticky;
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule